// File: doc/BRIEF.md
# Per-PC Local Access History Table

This block keeps a short, separate history of cache-line addresses for each load instruction address (PC). It is a two-level structure. The first level is a fully associative table of rows, each tagged with a full PC and replaced in least-recently-used order. The second level is the row itself, an age-ordered list of line addresses that accepts only lines it does not already hold. When the list is full, it drops its oldest line to make room.

On every valid access (PC, line address, two info bits), the table finds the row whose tag matches the PC, or takes over the least recently used row on a miss. It then pushes the line into that row unless the line is already present. All state updates at the clock edge after the access. One cycle after any line is logged, a trigger pulse reports which row changed, so that a downstream pattern detector can walk that row through the combinational read port. The read port always presents entry 0 as the newest line.

Top module: `lht_table`

## Requirements
- R1: After reset, every row is untagged (tag output 0) and empty (count 0). All read entries are invalid and return 0, the trigger is low, and allocations on a cold table take rows 0, 1, 2 and so on in ascending order.
- R2: An access whose PC equals the tag of a tagged row uses that row. At most one row ever matches a given PC.
- R3: An access whose PC matches no row reallocates the least recently used row. That row takes the new PC as its tag, has all its entries cleared, and holds the access as its only entry (index 0, count 1).
- R4: Every valid access, including one whose line is a duplicate, makes its row the most recently used. The replacement victim is always the row whose last access is oldest.
- R5: A line that is not held in the matching row is written at index 0. Every older entry moves one index up, and the count rises by one.
- R6: A line equal to any valid entry of the matching row, with the info bits ignored in the comparison, leaves that row's entries and count unchanged and produces no trigger.
- R7: A row holds at most DEPTH (24) entries. A new line pushed into a full row discards the entry at index DEPTH-1, and the count stays at DEPTH.
- R8: The read port is combinational from `rd_row_i` and `rd_idx_i`. Index 0 is the newest entry. `rd_valid_o` is 1 exactly when the index is below the row's count. For an invalid index, including indices of DEPTH and above, `rd_line_o` and `rd_info_o` read 0. `rd_count_o`, `rd_tagged_o` and `rd_pc_o` give the row's count, tag-valid flag and tag.
- R9: In the cycle after an access that logged a line (by allocation or by push), `trig_valid_o` is 1 and `trig_row_o` holds that row. In every other cycle, `trig_valid_o` is 0.
- R10: A cycle with `acc_valid_i` low changes no row, no tag and no LRU order, and raises no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_pc_i | input | PC_W (32) | PC of the access |
| acc_line_i | input | 26 | Line address of the access |
| acc_info_i | input | 2 | Info bits stored with the line |
| rd_row_i | input | log2(ROWS) | Row selected on the read port |
| rd_idx_i | input | log2(DEPTH) | Entry index, 0 is newest |
| rd_valid_o | output | 1 | Selected entry holds a line |
| rd_line_o | output | 26 | Line of the selected entry |
| rd_info_o | output | 2 | Info of the selected entry |
| rd_count_o | output | log2(DEPTH+1) | Number of entries in the selected row |
| rd_tagged_o | output | 1 | Selected row has a PC tag |
| rd_pc_o | output | PC_W (32) | Tag of the selected row |
| trig_valid_o | output | 1 | A line was logged last cycle |
| trig_row_o | output | log2(ROWS) | Row that logged it |

## Verification
The bench targets four kinds of corner case. The first is the duplicate access that must still refresh recency; a design that skips the touch would later evict a row that was just used. The second is the duplicate that differs only in its info bits; a design that compares the info would log the same line twice. The third is the push into a full row, where an off-by-one would either lose the newest line or let the count exceed DEPTH. The fourth is reallocation of a row with stale content, where a design that checks duplicates before the row is cleared would refuse to log the first line. A long random run with few PCs and few lines per PC keeps rows colliding, evicting and deduplicating at once. Throughout, the trigger and a sweep of the read port are compared against a queue-based model every cycle.

// File: rtl/lht_pkg.sv
package lht_pkg;

  localparam int unsigned LINE_W = 26;
  localparam int unsigned INFO_W = 2;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [INFO_W-1:0] info;
  } hist_ent_t;

  // Recency age of one row after a touch: the touched row becomes 0,
  // rows that were more recent than the touched one grow one step older.
  function automatic int unsigned age_after_touch(input int unsigned cur,
                                                  input int unsigned ref_age,
                                                  input bit          self);
    if (self)
      return 0;
    else if (cur < ref_age)
      return cur + 1;
    else
      return cur;
  endfunction

  // Fill level after a unique push into a row of the given depth.
  function automatic int unsigned count_after_push(input int unsigned cur,
                                                   input int unsigned depth);
    return (cur >= depth) ? depth : cur + 1;
  endfunction

endpackage

// File: rtl/lht_tags.sv
module lht_tags #(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  look_pc_i,
  input  logic             alloc_i,
  input  logic [ROW_W-1:0] alloc_row_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic             hit_o,
  output logic [ROW_W-1:0] hit_row_o,
  output logic [PC_W-1:0]  rd_pc_o,
  output logic             rd_tagged_o
);

  logic [PC_W-1:0] tags_q [ROWS];
  logic [ROWS-1:0] vld_q;
  logic [ROWS-1:0] match_vec;

  for (genvar g = 0; g < ROWS; g++) begin : g_cmp
    assign match_vec[g] = vld_q[g] && (tags_q[g] == look_pc_i);
  end

  assign hit_o = |match_vec;

  always_comb begin
    hit_row_o   = '0;
    rd_pc_o     = '0;
    rd_tagged_o = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      if (match_vec[i]) hit_row_o = ROW_W'(i);
      if (rd_row_i == ROW_W'(i)) begin
        rd_pc_o     = tags_q[i];
        rd_tagged_o = vld_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ROWS; i++) tags_q[i] <= '0;
    end else if (alloc_i) begin
      for (int i = 0; i < ROWS; i++) begin
        if (alloc_row_i == ROW_W'(i)) begin
          tags_q[i] <= look_pc_i;
          vld_q[i]  <= 1'b1;
        end
      end
    end
  end

  AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R2

  AST_ALLOC_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> vld_q[$past(alloc_row_i)] && (tags_q[$past(alloc_row_i)] == $past(look_pc_i))); // R3

endmodule

// File: rtl/lht_lru.sv
module lht_lru import lht_pkg::*; #(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [ROW_W-1:0] touch_row_i,
  output logic [ROW_W-1:0] victim_row_o
);

  localparam logic [ROW_W-1:0] OLDEST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] ages_q [ROWS];
  logic [ROW_W-1:0] ages_d [ROWS];
  logic [ROW_W-1:0] touched_age;
  logic [ROWS-1:0]  newest_vec;
  logic [ROWS-1:0]  oldest_vec;

  always_comb begin
    touched_age = '0;
    for (int i = 0; i < ROWS; i++)
      if (touch_row_i == ROW_W'(i)) touched_age = ages_q[i];
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_age
    assign ages_d[g]     = ROW_W'(age_after_touch(int'(ages_q[g]), int'(touched_age),
                                                  touch_row_i == ROW_W'(g)));
    assign newest_vec[g] = (ages_q[g] == '0);
    assign oldest_vec[g] = (ages_q[g] == OLDEST);
  end

  always_comb begin
    victim_row_o = '0;
    for (int i = 0; i < ROWS; i++)
      if (oldest_vec[i]) victim_row_o = ROW_W'(i);
  end

  // Reset order: row 0 is the oldest, so a cold table fills in ascending order.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) ages_q[i] <= ROW_W'(ROWS - 1 - i);
    end else if (touch_i) begin
      for (int i = 0; i < ROWS; i++) ages_q[i] <= ages_d[i];
    end
  end

  AST_ONE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(newest_vec)); // R4

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec)); // R4

  AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> ages_q[$past(touch_row_i)] == '0); // R4

  AST_IDLE_AGES: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_i |=> $stable(victim_row_o)); // R10

endmodule

// File: rtl/lht_row.sv
module lht_row import lht_pkg::*; #(
  parameter int unsigned DEPTH = 24,
  parameter int unsigned IDX_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              push_i,
  input  hist_ent_t         ent_i,
  input  logic [LINE_W-1:0] probe_line_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              dup_o,
  output hist_ent_t         rd_ent_o,
  output logic              rd_valid_o,
  output logic [CNT_W-1:0]  count_o
);

  hist_ent_t        ents_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] same_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    assign same_vec[g] = (CNT_W'(g) < cnt_q) && (ents_q[g].line == probe_line_i);
  end

  assign dup_o   = |same_vec;
  assign count_o = cnt_q;

  always_comb begin
    rd_ent_o   = '0;
    rd_valid_o = (int'(rd_idx_i) < int'(cnt_q));
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx_i == IDX_W'(i) && rd_valid_o) rd_ent_o = ents_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ents_q[i] <= '0;
    end else if (alloc_i) begin
      ents_q[0] <= ent_i;
      for (int i = 1; i < DEPTH; i++) ents_q[i] <= '0;
      cnt_q <= CNT_W'(1);
    end else if (push_i) begin
      ents_q[0] <= ent_i;
      for (int i = 1; i < DEPTH; i++) ents_q[i] <= ents_q[i-1];
      cnt_q <= CNT_W'(count_after_push(int'(cnt_q), DEPTH));
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH); // R7

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !alloc_i && int'(cnt_q) < DEPTH) |=> cnt_q == $past(cnt_q) + 1'b1); // R5

  AST_PUSH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i || alloc_i) |=> ents_q[0] == $past(ent_i)); // R5

  AST_ALLOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> cnt_q == CNT_W'(1)); // R3

  AST_QUIET_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_i && !push_i) |=> $stable(cnt_q) && $stable(ents_q[0])); // R6

endmodule

// File: rtl/lht_table.sv
module lht_table import lht_pkg::*; #(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned DEPTH = 24,
  parameter int unsigned PC_W  = 32,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic [PC_W-1:0]   acc_pc_i,
  input  logic [LINE_W-1:0] acc_line_i,
  input  logic [INFO_W-1:0] acc_info_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [INFO_W-1:0] rd_info_o,
  output logic [CNT_W-1:0]  rd_count_o,
  output logic              rd_tagged_o,
  output logic [PC_W-1:0]   rd_pc_o,
  output logic              trig_valid_o,
  output logic [ROW_W-1:0]  trig_row_o
);

  // Named internal events
  logic             upd_hit;
  logic [ROW_W-1:0] hit_row;
  logic [ROW_W-1:0] victim_row;
  logic [ROW_W-1:0] upd_row;
  logic             upd_alloc;
  logic             upd_dup;
  logic             upd_append;
  hist_ent_t        acc_ent;

  logic             row_dup   [ROWS];
  hist_ent_t        row_rd    [ROWS];
  logic             row_rdv   [ROWS];
  logic [CNT_W-1:0] row_cnt   [ROWS];
  logic             hit_dup;

  assign acc_ent = '{line: acc_line_i, info: acc_info_i};

  lht_tags #(.ROWS(ROWS), .PC_W(PC_W), .ROW_W(ROW_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .look_pc_i   (acc_pc_i),
    .alloc_i     (upd_alloc),
    .alloc_row_i (victim_row),
    .rd_row_i    (rd_row_i),
    .hit_o       (upd_hit),
    .hit_row_o   (hit_row),
    .rd_pc_o     (rd_pc_o),
    .rd_tagged_o (rd_tagged_o)
  );

  lht_lru #(.ROWS(ROWS), .ROW_W(ROW_W)) u_lru (
    .clk          (clk),
    .rst_n        (rst_n),
    .touch_i      (acc_valid_i),
    .touch_row_i  (upd_row),
    .victim_row_o (victim_row)
  );

  assign upd_row   = upd_hit ? hit_row : victim_row;
  assign upd_alloc = acc_valid_i && !upd_hit;

  always_comb begin
    hit_dup = 1'b0;
    for (int i = 0; i < ROWS; i++)
      if (hit_row == ROW_W'(i)) hit_dup = row_dup[i];
  end

  assign upd_dup    = acc_valid_i && upd_hit && hit_dup;
  assign upd_append = acc_valid_i && !upd_dup;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic sel;
    assign sel = (upd_row == ROW_W'(g));

    lht_row #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_row (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (upd_alloc && sel),
      .push_i       (upd_append && !upd_alloc && sel),
      .ent_i        (acc_ent),
      .probe_line_i (acc_line_i),
      .rd_idx_i     (rd_idx_i),
      .dup_o        (row_dup[g]),
      .rd_ent_o     (row_rd[g]),
      .rd_valid_o   (row_rdv[g]),
      .count_o      (row_cnt[g])
    );
  end

  always_comb begin
    rd_valid_o = 1'b0;
    rd_line_o  = '0;
    rd_info_o  = '0;
    rd_count_o = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (rd_row_i == ROW_W'(i)) begin
        rd_valid_o = row_rdv[i];
        rd_line_o  = row_rd[i].line;
        rd_info_o  = row_rd[i].info;
        rd_count_o = row_cnt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_valid_o <= 1'b0;
      trig_row_o   <= '0;
    end else begin
      trig_valid_o <= upd_append;
      trig_row_o   <= upd_row;
    end
  end

  AST_TRIG_AFTER_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_append |=> trig_valid_o && (trig_row_o == $past(upd_row))); // R9

  AST_NO_TRIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !trig_valid_o); // R10

  AST_NO_TRIG_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dup |=> !trig_valid_o); // R6

endmodule

// File: tb/lht_table_test.sv
module lht_table_test;

  localparam int ROWS  = 32;
  localparam int DEPTH = 24;
  localparam int PC_W  = 32;
  localparam int LW    = 26;
  localparam int IW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [31:0]   acc_pc = '0;
  logic [LW-1:0] acc_line = '0;
  logic [IW-1:0] acc_info = '0;
  logic [4:0]    rd_row = '0;
  logic [4:0]    rd_idx = '0;
  logic          rd_valid;
  logic [LW-1:0] rd_line;
  logic [IW-1:0] rd_info;
  logic [4:0]    rd_count;
  logic          rd_tagged;
  logic [31:0]   rd_pc;
  logic          trig_valid;
  logic [4:0]    trig_row;

  always #4 clk = ~clk;

  lht_table #(.ROWS(ROWS), .DEPTH(DEPTH), .PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid_i(acc_valid), .acc_pc_i(acc_pc), .acc_line_i(acc_line), .acc_info_i(acc_info),
    .rd_row_i(rd_row), .rd_idx_i(rd_idx),
    .rd_valid_o(rd_valid), .rd_line_o(rd_line), .rd_info_o(rd_info), .rd_count_o(rd_count),
    .rd_tagged_o(rd_tagged), .rd_pc_o(rd_pc),
    .trig_valid_o(trig_valid), .trig_row_o(trig_row)
  );

  // Behavioural reference model
  int            n_chk = 0;
  int            n_err = 0;
  string         cur_req = "R1";
  int            lru[$];          // front = most recent
  bit            m_tv  [ROWS];
  logic [31:0]   m_pc  [ROWS];
  logic [27:0]   m_h   [ROWS][DEPTH];
  int            m_cnt [ROWS];
  bit            exp_tv = 0;
  int            exp_tr = 0;
  int            last_row = 0;
  int            ridx = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    lru.delete();
    for (int r = ROWS - 1; r >= 0; r--) lru.push_back(r);
    for (int r = 0; r < ROWS; r++) begin
      m_tv[r] = 0; m_pc[r] = '0; m_cnt[r] = 0;
      for (int j = 0; j < DEPTH; j++) m_h[r][j] = '0;
    end
    exp_tv = 0;
  endtask

  task automatic model_access(input logic [31:0] pc, input logic [LW-1:0] line, input logic [IW-1:0] info);
    int r;
    bit dup;
    r = -1;
    dup = 0;
    exp_tv = 0;
    for (int i = 0; i < ROWS; i++) if (m_tv[i] && m_pc[i] == pc) r = i;
    if (r < 0) begin
      r = lru[lru.size() - 1];
      m_tv[r] = 1; m_pc[r] = pc;
      for (int j = 0; j < DEPTH; j++) m_h[r][j] = '0;
      m_h[r][0] = {line, info};
      m_cnt[r] = 1;
      exp_tv = 1;
    end else begin
      for (int j = 0; j < m_cnt[r]; j++) if (m_h[r][j][27:2] == line) dup = 1;
      if (!dup) begin
        for (int j = DEPTH - 1; j > 0; j--) m_h[r][j] = m_h[r][j-1];
        m_h[r][0] = {line, info};
        if (m_cnt[r] < DEPTH) m_cnt[r]++;
        exp_tv = 1;
      end
    end
    for (int k = 0; k < lru.size(); k++) begin
      if (lru[k] == r) begin
        lru.delete(k);
        break;
      end
    end
    lru.push_front(r);
    exp_tr = r;
    last_row = r;
  endtask

  task automatic cmp_entry(input int r, input int i);
    bit v;
    logic [27:0] e;
    v = (i < m_cnt[r]);
    e = (v && i < DEPTH) ? m_h[r][i] : 28'h0;
    chk($sformatf("R8 row%0d idx%0d valid", r, i), rd_valid, v);
    chk($sformatf("R8 row%0d idx%0d line", r, i), rd_line, e[27:2]);
    chk($sformatf("R8 row%0d idx%0d info", r, i), rd_info, e[1:0]);
    chk($sformatf("R8 row%0d count", r), rd_count, m_cnt[r]);
    chk($sformatf("R8 row%0d tagged", r), rd_tagged, m_tv[r]);
    chk($sformatf("R8 row%0d pc", r), rd_pc, m_pc[r]);
  endtask

  // One cycle: check the result of the previous cycle, then drive this one.
  task automatic step(input bit v, input logic [31:0] pc, input logic [LW-1:0] line, input logic [IW-1:0] info);
    @(negedge clk);
    rd_row = 5'(last_row);
    rd_idx = 5'(ridx);
    #1;
    chk("R9 trig_valid", trig_valid, exp_tv);
    if (exp_tv) chk("R9 trig_row", trig_row, exp_tr);
    cmp_entry(last_row, ridx);
    ridx = (ridx + 1) % (DEPTH + 1);
    acc_valid = v; acc_pc = pc; acc_line = line; acc_info = info;
    if (v) model_access(pc, line, info);
    else exp_tv = 0;
  endtask

  task automatic acc(input logic [31:0] pc, input logic [LW-1:0] line, input logic [IW-1:0] info);
    step(1'b1, pc, line, info);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, '0);
  endtask

  task automatic dump_all();
    idle(2);
    for (int r = 0; r < ROWS; r++) begin
      for (int i = 0; i <= DEPTH; i++) begin
        rd_row = 5'(r); rd_idx = 5'(i);
        #1;
        cmp_entry(r, i);
      end
      rd_idx = 5'd31;
      #1;
      cmp_entry(r, 31);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  localparam logic [31:0] PCA = 32'h0040_1000;

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: cold state
    cur_req = "R1";
    dump_all();

    // R3: first allocation lands in row 0
    cur_req = "R3";
    acc(PCA, 26'd100, 2'd1);
    idle(1);
    cur_req = "R1";
    chk("R1 first alloc row", last_row, 0);

    // R6: duplicates, including a different info value
    cur_req = "R6";
    acc(PCA, 26'd100, 2'd2);
    acc(PCA, 26'd100, 2'd1);
    idle(1);
    dump_all();

    // R5: unique pushes, newest first
    cur_req = "R5";
    acc(PCA, 26'd101, 2'd0);
    acc(PCA, 26'd102, 2'd3);
    acc(PCA, 26'd103, 2'd2);
    acc(PCA, 26'd101, 2'd0);
    dump_all();

    // R7: overflow the row
    cur_req = "R7";
    for (int k = 0; k < 30; k++) acc(PCA, 26'(200 + k), 2'(k));
    dump_all();

    // R2 R4: fill the table, refresh row 0, then force replacement
    cur_req = "R2";
    for (int k = 1; k < ROWS; k++) acc(32'h0080_0000 + 32'(k * 4), 26'(1000 + k), 2'd0);
    acc(PCA, 26'd229, 2'd0);
    cur_req = "R4";
    acc(32'h00C0_0000, 26'd5000, 2'd1);
    chk("R4 victim after refresh", last_row, 1);
    acc(32'h0080_0004, 26'd6000, 2'd2);
    chk("R4 evicted pc reallocates", last_row, 2);
    cur_req = "R3";
    dump_all();

    // R10: idle cycles change nothing
    cur_req = "R10";
    idle(6);
    dump_all();

    // R4 R5 R6 R7 random mix
    cur_req = "R4 R5 R6 R7 random";
    for (int n = 0; n < 3000; n++) begin
      int p;
      p = int'($urandom % 40);
      acc(32'h1000_0000 + 32'(p * 8), 26'((p << 8) + int'($urandom % 30)), 2'($urandom % 4));
      if ($urandom % 8 == 0) idle(1);
      if (n % 750 == 749) dump_all();
    end
    dump_all();

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule